// File: doc/BRIEF.md
# DSI Video Frame Timing Generator

This block is the frame timing source for a display serial host running in video mode with sync pulses. It runs on the lane byte clock and marks where each line and frame is: the sync, back porch, active and front porch phases on both axes, plus pulses for line start, frame start and the start and end of each sync pulse. Packet generation and the pixel datapath sit downstream and use these marks.

Software supplies a panel mode: horizontal values in pixels (active, blanking, sync offset, sync width), vertical values in lines (same four), the pixel clock and the per-lane bit rate in the same frequency unit. A one-cycle load strobe captures the mode. The block rejects an inconsistent mode. Otherwise it converts the four horizontal spans to byte-clock cycles, one after another, in a shared serial divider. Each conversion is ceil(pixels * lane_rate / (8 * pixel_clock)). Counting starts as soon as the last conversion lands.

Top module: `dsi_vtg`

## Requirements
- R1: A load whose horizontal blanking is less than sync offset plus sync width, whose vertical blanking is less than vertical offset plus width, or whose active-plus-blanking total is zero on either axis sets cfg_err_o to 1 and keeps cfg_valid_o at 0. cfg_err_o stays set until the next load. A zero pixel clock is rejected the same way.
- R2: The horizontal spans in byte-clock cycles are ceil(px * lane_rate / (8 * pclk)). The line length uses active+blanking. Sync uses the sync width. Back porch uses blanking-offset-width. Active uses the active pixels. A line lasts exactly the converted total.
- R3: Within a line, h_phase_o steps through sync (code 0), back porch (1), active (2) and front porch (3). Each phase lasts its converted count. Front porch is whatever remains of the line. A phase of zero length is skipped.
- R4: Within a frame of active+blanking lines, v_phase_o steps through sync (0) for the sync-width lines, back porch (1) for blanking-offset-width lines, active (2) for the active lines, then front porch (3) for the sync-offset lines. It changes only at a line start.
- R5: line_start_o pulses on the first cycle of every line. frame_start_o pulses on the first cycle of line 0 only.
- R6: hsync_start_o pulses on the first cycle of a line and hsync_end_o on the last cycle of the horizontal sync phase. Neither pulses when the sync width is zero.
- R7: vsync_start_o pulses together with frame_start_o. vsync_end_o pulses on the last cycle of the last vertical sync line. Neither pulses when the vertical sync width is zero.
- R8: pixel_window_o is 1 exactly when both phases are active (code 2).
- R9: A lane rate of zero, or one at or above MAX_RATE, is rejected as in R1. MAX_RATE-1 is accepted.
- R10: A load drops cfg_valid_o on the next cycle. The first cycle with cfg_valid_o high is cycle 0 of line 0 of the new mode, and counting then repeats frame after frame.
- R11: After reset and while not valid, cfg_valid_o and cfg_err_o are 0. Both phases read 3 and every pulse output and pixel_window_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Lane byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture the mode inputs and start conversion |
| h_active_i | input | PX_W | Active pixels per line |
| h_blank_i | input | PX_W | Blanking pixels per line |
| h_sync_off_i | input | PX_W | Pixels from end of active to sync |
| h_sync_wid_i | input | PX_W | Horizontal sync width in pixels |
| v_active_i | input | LN_W | Active lines per frame |
| v_blank_i | input | LN_W | Blanking lines per frame |
| v_sync_off_i | input | LN_W | Lines from end of active to sync |
| v_sync_wid_i | input | LN_W | Vertical sync width in lines |
| pclk_i | input | PCLK_W | Pixel clock frequency |
| lane_rate_i | input | RATE_W | Per-lane bit rate, same unit as pclk_i |
| cfg_valid_o | output | 1 | Mode converted, generator counting |
| cfg_err_o | output | 1 | Last loaded mode rejected |
| h_phase_o | output | 2 | Horizontal phase code |
| v_phase_o | output | 2 | Vertical phase code |
| pixel_window_o | output | 1 | Active region on both axes |
| line_start_o | output | 1 | First cycle of a line |
| frame_start_o | output | 1 | First cycle of a frame |
| hsync_start_o | output | 1 | First cycle of horizontal sync |
| hsync_end_o | output | 1 | Last cycle of horizontal sync |
| vsync_start_o | output | 1 | First cycle of vertical sync |
| vsync_end_o | output | 1 | Last cycle of vertical sync |

## Verification
The bench builds the block with PX_W=10, LN_W=6, RATE_W=21, PCLK_W=21 and MAX_RATE=1500000. These widths keep each conversion at 32 divider steps. They also let the mode values run down to a one-cycle line and up to the rate ceiling. It sweeps sync widths, offsets and three rate-to-clock ratios: below one, exactly one and above one cycle per pixel. This exercises the upward rounding, zero-length sync and back porch phases, and full-line sync. Each mode is checked over two whole frames. Reloads happen mid-frame, and each rejection cause is loaded in turn, including the rate limit on both sides of MAX_RATE.

// File: rtl/dsi_vtg_pkg.sv
package dsi_vtg_pkg;
  typedef enum logic [1:0] {
    PH_SYNC   = 2'd0,
    PH_BACK   = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_FRONT  = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    CS_IDLE = 2'd0,
    CS_CONV = 2'd1,
    CS_RUN  = 2'd2,
    CS_ERR  = 2'd3
  } cfg_state_e;
endpackage

// File: rtl/dsi_vtg_div.sv
// Radix-2 restoring divider, quotient rounded up.
module dsi_vtg_div #(
  parameter int NUM_W = 32,
  parameter int DEN_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quot_o
);
  localparam int CNT_W = $clog2(NUM_W + 1);
  localparam int PW    = NUM_W + DEN_W;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(NUM_W);
  localparam logic [NUM_W-1:0] Q_ONE    = NUM_W'(1);

  logic [NUM_W-1:0] sh_q, quo_q, num_q;
  logic [DEN_W-1:0] den_q, rem_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic [DEN_W:0]   trial;
  logic             take;

  assign trial = {rem_q, sh_q[NUM_W-1]};
  assign take  = trial >= {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      quo_q  <= '0;
      num_q  <= '0;
      den_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_o <= 1'b0;
    end else if (start_i) begin
      sh_q   <= num_i;
      num_q  <= num_i;
      den_q  <= den_i;
      quo_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= CNT_INIT;
      busy_q <= 1'b1;
      done_o <= 1'b0;
    end else if (busy_q) begin
      rem_q <= take ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
      quo_q <= {quo_q[NUM_W-2:0], take};
      sh_q  <= {sh_q[NUM_W-2:0], 1'b0};
      cnt_q <= cnt_q - CNT_ONE;
      if (cnt_q == CNT_ONE) begin
        busy_q <= 1'b0;
        done_o <= 1'b1;
      end
    end else begin
      done_o <= 1'b0;
    end
  end

  assign quot_o = quo_q + NUM_W'(rem_q != '0);

  logic [PW-1:0] prod_hi, prod_lo, num_ext;
  assign prod_hi = PW'(quot_o) * PW'(den_q);
  assign prod_lo = PW'(quot_o - Q_ONE) * PW'(den_q);
  assign num_ext = PW'(num_q);

  // R2: quotient is the smallest value whose product covers the numerator
  p_ceil_quot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (prod_hi >= num_ext) && ((quot_o == '0) || (prod_lo < num_ext)));
endmodule

// File: rtl/dsi_vtg_cfg.sv
module dsi_vtg_cfg
  import dsi_vtg_pkg::*;
#(
  parameter int PX_W     = 12,
  parameter int LN_W     = 12,
  parameter int RATE_W   = 21,
  parameter int PCLK_W   = 21,
  parameter int MAX_RATE = 1500000,
  parameter int NUM_W    = PX_W + 1 + RATE_W,
  parameter int DEN_W    = PCLK_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [PX_W-1:0]   h_active_i,
  input  logic [PX_W-1:0]   h_blank_i,
  input  logic [PX_W-1:0]   h_sync_off_i,
  input  logic [PX_W-1:0]   h_sync_wid_i,
  input  logic [LN_W-1:0]   v_active_i,
  input  logic [LN_W-1:0]   v_blank_i,
  input  logic [LN_W-1:0]   v_sync_off_i,
  input  logic [LN_W-1:0]   v_sync_wid_i,
  input  logic [PCLK_W-1:0] pclk_i,
  input  logic [RATE_W-1:0] lane_rate_i,
  output logic              cfg_valid_o,
  output logic              cfg_err_o,
  output logic [NUM_W-1:0]  ht_cyc_o,
  output logic [NUM_W-1:0]  hsa_cyc_o,
  output logic [NUM_W-1:0]  hbp_cyc_o,
  output logic [NUM_W-1:0]  hac_cyc_o,
  output logic [LN_W-1:0]   vsa_o,
  output logic [LN_W-1:0]   vbp_o,
  output logic [LN_W-1:0]   vac_o,
  output logic [LN_W:0]     vt_o
);
  localparam logic [RATE_W-1:0] RATE_LIM = RATE_W'(MAX_RATE);

  cfg_state_e       st_q;
  logic [1:0]       idx_q;
  logic             div_start_q;
  logic [PX_W:0]    htot_px_q;
  logic [PX_W-1:0]  hsa_px_q, hbp_px_q, hac_px_q;
  logic [RATE_W-1:0] rate_q;
  logic [PCLK_W-1:0] pclk_q;

  // load-time checks
  logic [PX_W:0] h_need, h_tot;
  logic [LN_W:0] v_need, v_tot;
  logic          bad_h, bad_v, bad_rate, bad_clk, bad;

  assign h_need   = {1'b0, h_sync_off_i} + {1'b0, h_sync_wid_i};
  assign h_tot    = {1'b0, h_active_i} + {1'b0, h_blank_i};
  assign v_need   = {1'b0, v_sync_off_i} + {1'b0, v_sync_wid_i};
  assign v_tot    = {1'b0, v_active_i} + {1'b0, v_blank_i};
  assign bad_h    = (h_need > {1'b0, h_blank_i}) || (h_tot == '0);
  assign bad_v    = (v_need > {1'b0, v_blank_i}) || (v_tot == '0);
  assign bad_rate = (lane_rate_i == '0) || (lane_rate_i >= RATE_LIM);
  assign bad_clk  = (pclk_i == '0);
  assign bad      = bad_h || bad_v || bad_rate || bad_clk;

  // shared divider, one span at a time
  logic [PX_W:0]      px_sel;
  logic [NUM_W-1:0]   div_num, div_quot;
  logic [DEN_W-1:0]   div_den;
  logic               div_done;

  always_comb begin
    unique case (idx_q)
      2'd0:    px_sel = htot_px_q;
      2'd1:    px_sel = {1'b0, hsa_px_q};
      2'd2:    px_sel = {1'b0, hbp_px_q};
      default: px_sel = {1'b0, hac_px_q};
    endcase
  end

  assign div_num = NUM_W'(px_sel) * NUM_W'(rate_q);
  assign div_den = {pclk_q, 3'b000};

  dsi_vtg_div #(
    .NUM_W(NUM_W),
    .DEN_W(DEN_W)
  ) div_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(div_start_q),
    .num_i  (div_num),
    .den_i  (div_den),
    .done_o (div_done),
    .quot_o (div_quot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= CS_IDLE;
      idx_q       <= 2'd0;
      div_start_q <= 1'b0;
      htot_px_q   <= '0;
      hsa_px_q    <= '0;
      hbp_px_q    <= '0;
      hac_px_q    <= '0;
      rate_q      <= '0;
      pclk_q      <= '0;
      ht_cyc_o    <= '0;
      hsa_cyc_o   <= '0;
      hbp_cyc_o   <= '0;
      hac_cyc_o   <= '0;
      vsa_o       <= '0;
      vbp_o       <= '0;
      vac_o       <= '0;
      vt_o        <= '0;
    end else begin
      div_start_q <= 1'b0;
      if (load_i) begin
        htot_px_q <= h_tot;
        hsa_px_q  <= h_sync_wid_i;
        hbp_px_q  <= h_blank_i - h_sync_off_i - h_sync_wid_i;
        hac_px_q  <= h_active_i;
        rate_q    <= lane_rate_i;
        pclk_q    <= pclk_i;
        vsa_o     <= v_sync_wid_i;
        vbp_o     <= v_blank_i - v_sync_off_i - v_sync_wid_i;
        vac_o     <= v_active_i;
        vt_o      <= v_tot;
        idx_q     <= 2'd0;
        if (bad) begin
          st_q <= CS_ERR;
        end else begin
          st_q        <= CS_CONV;
          div_start_q <= 1'b1;
        end
      end else if (st_q == CS_CONV && div_done && !div_start_q) begin
        unique case (idx_q)
          2'd0:    ht_cyc_o  <= div_quot;
          2'd1:    hsa_cyc_o <= div_quot;
          2'd2:    hbp_cyc_o <= div_quot;
          default: hac_cyc_o <= div_quot;
        endcase
        if (idx_q == 2'd3) begin
          st_q <= CS_RUN;
        end else begin
          idx_q       <= idx_q + 2'd1;
          div_start_q <= 1'b1;
        end
      end
    end
  end

  assign cfg_valid_o = (st_q == CS_RUN);
  assign cfg_err_o   = (st_q == CS_ERR);

  p_err_excl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_err_o && cfg_valid_o));
  p_load_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !cfg_valid_o);
  p_rate_reject_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && (lane_rate_i >= RATE_LIM) |=> cfg_err_o);
endmodule

// File: rtl/dsi_vtg_cnt.sv
module dsi_vtg_cnt
  import dsi_vtg_pkg::*;
#(
  parameter int CYC_W = 32,
  parameter int LN_W  = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CYC_W-1:0] ht_i,
  input  logic [CYC_W-1:0] hsa_i,
  input  logic [CYC_W-1:0] hbp_i,
  input  logic [CYC_W-1:0] hac_i,
  input  logic [LN_W-1:0]  vsa_i,
  input  logic [LN_W-1:0]  vbp_i,
  input  logic [LN_W-1:0]  vac_i,
  input  logic [LN_W:0]    vt_i,
  output logic [1:0]       h_phase_o,
  output logic [1:0]       v_phase_o,
  output logic             pixel_window_o,
  output logic             line_start_o,
  output logic             frame_start_o,
  output logic             hsync_start_o,
  output logic             hsync_end_o,
  output logic             vsync_start_o,
  output logic             vsync_end_o
);
  localparam logic [CYC_W-1:0] C_ONE = CYC_W'(1);
  localparam logic [LN_W:0]    L_ONE = (LN_W + 1)'(1);

  logic [CYC_W-1:0] hcnt_q;
  logic [LN_W:0]    vln_q;
  logic             line_end, frame_end;

  assign line_end  = (hcnt_q == ht_i - C_ONE);
  assign frame_end = (vln_q == vt_i - L_ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q <= '0;
      vln_q  <= '0;
    end else if (!run_i) begin
      hcnt_q <= '0;
      vln_q  <= '0;
    end else if (line_end) begin
      hcnt_q <= '0;
      vln_q  <= frame_end ? '0 : vln_q + L_ONE;
    end else begin
      hcnt_q <= hcnt_q + C_ONE;
    end
  end

  // phase boundaries, widened so sums cannot wrap
  logic [CYC_W+1:0] hb1, hb2, hb3, hpos;
  logic [LN_W+1:0]  vb1, vb2, vb3, vpos;

  assign hb1  = {2'b00, hsa_i};
  assign hb2  = hb1 + {2'b00, hbp_i};
  assign hb3  = hb2 + {2'b00, hac_i};
  assign hpos = {2'b00, hcnt_q};
  assign vb1  = {2'b00, vsa_i};
  assign vb2  = vb1 + {2'b00, vbp_i};
  assign vb3  = vb2 + {2'b00, vac_i};
  assign vpos = {1'b0, vln_q};

  always_comb begin
    h_phase_o = PH_FRONT;
    v_phase_o = PH_FRONT;
    if (run_i) begin
      if (hpos < hb1)      h_phase_o = PH_SYNC;
      else if (hpos < hb2) h_phase_o = PH_BACK;
      else if (hpos < hb3) h_phase_o = PH_ACTIVE;
      if (vpos < vb1)      v_phase_o = PH_SYNC;
      else if (vpos < vb2) v_phase_o = PH_BACK;
      else if (vpos < vb3) v_phase_o = PH_ACTIVE;
    end
  end

  logic hs_on, vs_on;
  assign hs_on = (hsa_i != '0);
  assign vs_on = (vsa_i != '0);

  assign pixel_window_o = (h_phase_o == PH_ACTIVE) && (v_phase_o == PH_ACTIVE);
  assign line_start_o   = run_i && (hcnt_q == '0);
  assign frame_start_o  = line_start_o && (vln_q == '0);
  assign hsync_start_o  = line_start_o && hs_on;
  assign hsync_end_o    = run_i && hs_on && (hcnt_q == hsa_i - C_ONE);
  assign vsync_start_o  = frame_start_o && vs_on;
  assign vsync_end_o    = run_i && vs_on && line_end &&
                          (vln_q == {1'b0, vsa_i} - L_ONE);

  p_hcnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (hcnt_q < ht_i));
  p_hphase_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && $past(run_i) && !line_start_o |-> h_phase_o >= $past(h_phase_o));
  p_vphase_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && $past(run_i) && !line_start_o |-> $stable(v_phase_o));
  p_hsync_end_in_sync_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsync_end_o |-> h_phase_o == PH_SYNC);
  p_vsync_end_in_sync_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_end_o |-> v_phase_o == PH_SYNC);
endmodule

// File: rtl/dsi_vtg.sv
module dsi_vtg #(
  parameter int PX_W     = 12,
  parameter int LN_W     = 12,
  parameter int RATE_W   = 21,
  parameter int PCLK_W   = 21,
  parameter int MAX_RATE = 1500000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [PX_W-1:0]   h_active_i,
  input  logic [PX_W-1:0]   h_blank_i,
  input  logic [PX_W-1:0]   h_sync_off_i,
  input  logic [PX_W-1:0]   h_sync_wid_i,
  input  logic [LN_W-1:0]   v_active_i,
  input  logic [LN_W-1:0]   v_blank_i,
  input  logic [LN_W-1:0]   v_sync_off_i,
  input  logic [LN_W-1:0]   v_sync_wid_i,
  input  logic [PCLK_W-1:0] pclk_i,
  input  logic [RATE_W-1:0] lane_rate_i,
  output logic              cfg_valid_o,
  output logic              cfg_err_o,
  output logic [1:0]        h_phase_o,
  output logic [1:0]        v_phase_o,
  output logic              pixel_window_o,
  output logic              line_start_o,
  output logic              frame_start_o,
  output logic              hsync_start_o,
  output logic              hsync_end_o,
  output logic              vsync_start_o,
  output logic              vsync_end_o
);
  localparam int NUM_W = PX_W + 1 + RATE_W;
  localparam int DEN_W = PCLK_W + 3;

  logic [NUM_W-1:0] ht_cyc, hsa_cyc, hbp_cyc, hac_cyc;
  logic [LN_W-1:0]  vsa, vbp, vac;
  logic [LN_W:0]    vt;

  dsi_vtg_cfg #(
    .PX_W    (PX_W),
    .LN_W    (LN_W),
    .RATE_W  (RATE_W),
    .PCLK_W  (PCLK_W),
    .MAX_RATE(MAX_RATE),
    .NUM_W   (NUM_W),
    .DEN_W   (DEN_W)
  ) cfg_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_i),
    .h_active_i  (h_active_i),
    .h_blank_i   (h_blank_i),
    .h_sync_off_i(h_sync_off_i),
    .h_sync_wid_i(h_sync_wid_i),
    .v_active_i  (v_active_i),
    .v_blank_i   (v_blank_i),
    .v_sync_off_i(v_sync_off_i),
    .v_sync_wid_i(v_sync_wid_i),
    .pclk_i      (pclk_i),
    .lane_rate_i (lane_rate_i),
    .cfg_valid_o (cfg_valid_o),
    .cfg_err_o   (cfg_err_o),
    .ht_cyc_o    (ht_cyc),
    .hsa_cyc_o   (hsa_cyc),
    .hbp_cyc_o   (hbp_cyc),
    .hac_cyc_o   (hac_cyc),
    .vsa_o       (vsa),
    .vbp_o       (vbp),
    .vac_o       (vac),
    .vt_o        (vt)
  );

  dsi_vtg_cnt #(
    .CYC_W(NUM_W),
    .LN_W (LN_W)
  ) cnt_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .run_i         (cfg_valid_o),
    .ht_i          (ht_cyc),
    .hsa_i         (hsa_cyc),
    .hbp_i         (hbp_cyc),
    .hac_i         (hac_cyc),
    .vsa_i         (vsa),
    .vbp_i         (vbp),
    .vac_i         (vac),
    .vt_i          (vt),
    .h_phase_o     (h_phase_o),
    .v_phase_o     (v_phase_o),
    .pixel_window_o(pixel_window_o),
    .line_start_o  (line_start_o),
    .frame_start_o (frame_start_o),
    .hsync_start_o (hsync_start_o),
    .hsync_end_o   (hsync_end_o),
    .vsync_start_o (vsync_start_o),
    .vsync_end_o   (vsync_end_o)
  );
endmodule

// File: tb/dsi_vtg_tb_top.sv
`timescale 1ns/1ps
module dsi_vtg_tb_top;
  localparam int PX_W = 10, LN_W = 6, RATE_W = 21, PCLK_W = 21;
  localparam int MAX_RATE = 1500000;

  logic clk = 1'b0, rst_ni = 1'b0, load = 1'b0;
  logic [PX_W-1:0] ha = '0, hbl = '0, hso = '0, hsw = '0;
  logic [LN_W-1:0] va = '0, vbl = '0, vso = '0, vsw = '0;
  logic [PCLK_W-1:0] pclk = '0;
  logic [RATE_W-1:0] rate = '0;
  logic valid, err, pw, ls, fs, hss, hse, vss, vse;
  logic [1:0] hph, vph;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dsi_vtg #(.PX_W(PX_W), .LN_W(LN_W), .RATE_W(RATE_W), .PCLK_W(PCLK_W),
            .MAX_RATE(MAX_RATE)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .load_i(load),
    .h_active_i(ha), .h_blank_i(hbl), .h_sync_off_i(hso), .h_sync_wid_i(hsw),
    .v_active_i(va), .v_blank_i(vbl), .v_sync_off_i(vso), .v_sync_wid_i(vsw),
    .pclk_i(pclk), .lane_rate_i(rate),
    .cfg_valid_o(valid), .cfg_err_o(err), .h_phase_o(hph), .v_phase_o(vph),
    .pixel_window_o(pw), .line_start_o(ls), .frame_start_o(fs),
    .hsync_start_o(hss), .hsync_end_o(hse), .vsync_start_o(vss), .vsync_end_o(vse));

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL R10 watchdog actual %0d expected below 190000", cyc);
      summary();
      $finish;
    end
  end

  function automatic longint cdiv(longint px, longint r, longint p);
    return (px * r + 8 * p - 1) / (8 * p);
  endfunction

  task automatic chk_idle(string req);
    chk({req, " valid"}, valid, 0);
    chk({req, " h_phase idle"}, hph, 3);
    chk({req, " v_phase idle"}, vph, 3);
    chk({req, " pulses idle"}, {pw, ls, fs, hss, hse, vss, vse}, 0);
  endtask

  task automatic do_load(int a, int b, int so, int sw, int c, int d, int vo, int vw,
                         int pc, int rt);
    ha = PX_W'(a); hbl = PX_W'(b); hso = PX_W'(so); hsw = PX_W'(sw);
    va = LN_W'(c); vbl = LN_W'(d); vso = LN_W'(vo); vsw = LN_W'(vw);
    pclk = PCLK_W'(pc); rate = RATE_W'(rt);
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    chk("R10 valid drops after load", valid, 0);
  endtask

  task automatic bad_cfg(string req, int a, int b, int so, int sw, int c, int d,
                         int vo, int vw, int pc, int rt);
    do_load(a, b, so, sw, c, d, vo, vw, pc, rt);
    for (int i = 0; i < 3; i++) begin
      chk({req, " err set"}, err, 1);
      chk_idle(req);
      @(negedge clk);
    end
  endtask

  task automatic run_cfg(int a, int b, int so, int sw, int c, int d, int vo, int vw,
                         int pc, int rt);
    longint ht, hsa, hbp, hac, vt, vsa, vbp, n;
    int w;
    do_load(a, b, so, sw, c, d, vo, vw, pc, rt);
    w = 0;
    while (!valid && w < 400) begin
      @(negedge clk);
      w++;
    end
    chk("R10 valid reached", valid, 1);
    chk("R1 no error on good mode", err, 0);
    ht  = cdiv(a + b, rt, pc);
    hsa = cdiv(sw, rt, pc);
    hbp = cdiv(b - so - sw, rt, pc);
    hac = cdiv(a, rt, pc);
    vt  = c + d;
    vsa = vw;
    vbp = d - vo - vw;
    n   = 2 * ht * vt + 2;
    for (longint k = 0; k < n; k++) begin
      longint lk, ln, cc;
      int eh, ev;
      lk = k % (ht * vt);
      ln = lk / ht;
      cc = lk % ht;
      eh = (cc < hsa) ? 0 : (cc < hsa + hbp) ? 1 : (cc < hsa + hbp + hac) ? 2 : 3;
      ev = (ln < vsa) ? 0 : (ln < vsa + vbp) ? 1 : (ln < vsa + vbp + c) ? 2 : 3;
      chk("R2 R3 h_phase", hph, eh);
      chk("R4 v_phase", vph, ev);
      chk("R8 pixel_window", pw, (eh == 2 && ev == 2));
      chk("R5 line_start", ls, (cc == 0));
      chk("R5 frame_start", fs, (cc == 0 && ln == 0));
      chk("R6 hsync_start", hss, (cc == 0 && hsa != 0));
      chk("R6 hsync_end", hse, (hsa != 0 && cc == hsa - 1));
      chk("R7 vsync_start", vss, (cc == 0 && ln == 0 && vsa != 0));
      chk("R7 vsync_end", vse, (vsa != 0 && ln == vsa - 1 && cc == ht - 1));
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 err in reset", err, 0);
    chk_idle("R11 reset");
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R11 err after reset", err, 0);
    chk_idle("R11 after reset");

    // sweep: sync widths, offsets, three rate/clock ratios
    for (int r = 0; r < 3; r++) begin
      for (int s = 0; s < 3; s++) begin
        for (int o = 0; o < 2; o++) begin
          for (int v = 0; v < 3; v++) begin
            int rt, sw;
            rt = (r == 0) ? 24 : (r == 1) ? 80 : 130;
            sw = (s == 0) ? 0 : (s == 1) ? 1 : 3;
            run_cfg(12 + r, 8, 2 * o, sw, 3, 5, 2 * o, v, 10, rt);
          end
        end
      end
    end

    // corners: one-cycle line, full-line sync, zero back porch
    run_cfg(1, 0, 0, 0, 1, 1, 0, 1, 10, 80);
    run_cfg(0, 3, 0, 3, 2, 2, 1, 1, 10, 80);
    run_cfg(5, 4, 1, 3, 2, 3, 1, 2, 7, 33);

    // rejections
    bad_cfg("R1 h blank short", 8, 4, 2, 3, 3, 5, 1, 1, 10, 80);
    bad_cfg("R1 v blank short", 8, 6, 2, 3, 3, 2, 1, 2, 10, 80);
    bad_cfg("R1 zero h total", 0, 0, 0, 0, 3, 5, 1, 1, 10, 80);
    bad_cfg("R1 zero v total", 8, 6, 1, 1, 0, 0, 0, 0, 10, 80);
    bad_cfg("R1 zero pclk", 8, 6, 1, 1, 3, 5, 1, 1, 0, 80);
    bad_cfg("R9 rate at limit", 8, 6, 1, 1, 3, 5, 1, 1, 10, MAX_RATE);
    bad_cfg("R9 rate zero", 8, 6, 1, 1, 3, 5, 1, 1, 10, 0);

    // just below the limit is accepted
    do_load(8, 6, 1, 1, 3, 5, 1, 1, 10, MAX_RATE - 1);
    for (int i = 0; i < 300 && !valid; i++) @(negedge clk);
    chk("R9 rate below limit valid", valid, 1);
    chk("R9 rate below limit err", err, 0);

    // recovery from an error state with a good mode
    bad_cfg("R1 before recovery", 8, 4, 2, 3, 3, 5, 1, 1, 10, 80);
    run_cfg(6, 4, 1, 2, 2, 3, 1, 1, 10, 80);

    finished = 1;
    summary();
    $finish;
  end
endmodule